// File: doc/BRIEF.md
# OTP Fuse Controller with Shadow Words

This block sits behind a simple 32-bit register bus and manages a bank of one-time-programmable 32-bit words (96 by default). Each word has two copies: a fuse word, modelled as bits that can only go from 0 to 1, and a shadow word that software reads and writes at any time. Software first raises a fuse power request and polls a ready flag. It then issues commands through a control register: reload a shadow from its fuse word, program fuse bits by OR-ing in the write-data register, or burn a permanent write lock on a group of words. Every command keeps the block busy for a fixed number of cycles.

Per-word sticky lock bitmaps, which software can only set, gate the block's actions. The shadow-read lock makes a reload load zero. The shadow-write lock makes bus writes to the shadow ignored. The program lock makes programming ignored. A global lock register adds a bit that blocks all programming. Read-only bitmaps record per-word errors, disturbed reloads and permanent locks. A debug register reports the state of an external debug-enable input.

The command sequencer has three states. FSM_IDLE moves to FSM_WAIT when a control write is accepted. FSM_WAIT stays until its down-counter reaches zero, then moves to FSM_APPLY. FSM_APPLY commits the command's effect and returns to FSM_IDLE on the next edge.

Top module: `otp_fuse_ctl`

## Requirements
- R1: After reset every shadow word reads 0, every bitmap and the global lock read 0, and status reads 0 (power not ready, not busy, no failure).
- R2: Status bit 5 (power ready) follows config bit 0 (offset 0x000), changing PWR_DELAY clock edges after the edge that wrote the config bit.
- R3: A control write (offset 0x004) accepted in idle holds status bit 3 (busy) high for exactly BUSY_CYCLES cycles. Control writes made while busy are ignored.
- R4: A control word with bit 8 clear reloads the word numbered in its low bits: the shadow (offset 0x200 + 4·n) takes the fuse value.
- R5: A control word with bit 8 set and bit 9 clear ORs the write-data register (offset 0x008) into the fuse word. The shadow is unchanged until a reload.
- R6: A reload, program or lock command executed while power is not ready has no effect and sets status bit 4 (program failed). For a word command it also sets the word's bit in the error bitmap (0x034 + 4·bank, bit word mod 32). Bit 4 clears when the next command is accepted, and a successful command clears the word's error bit.
- R7: A reload of a word whose shadow-read lock (0x094 + 4·bank) is set loads 0 into the shadow and sets the word's disturbed bit (0x01C + 4·bank).
- R8: A bus write to a shadow whose shadow-write lock (0x07C + 4·bank) is set is ignored.
- R9: A program of a word whose program lock (0x064 + 4·bank) is set, or while global lock (0x010) bit 4 is set, is ignored without setting program failed.
- R10: Control bits 9 and 8 both set request a permanent lock of group g (low bits). For g below 4, word 8g+k is locked when write-data bits 2k or 2k+1 are set. For g from 4 to 7, word 32+16(g−4)+k is locked when bit k is set. Locks appear in the bitmap at 0x04C + 4·bank. Programming a locked word sets program failed and leaves the fuse unchanged.
- R11: Sticky lock bitmaps and the global lock only accumulate ones: writing zeros clears nothing.
- R12: A reload or program of a word number of NUM_WORDS or more, or a lock of a group above 7, sets program failed and changes nothing.
- R13: Bit 10 of offset 0x014 reads the debug-enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| dbg_en_i | input | 1 | Debug-enable level reported in the debug register |

## Verification
The assertions assume a well-formed bus. They take bus_we and bus_addr as settled on each rising edge, with no unknown values. They also assume the power request does not toggle faster than the handshake can follow. The bench meets this by driving every input at the falling edge, holding a write strobe for exactly one rising edge, and waiting for the ready flag to settle after each config change. Every command is given BUSY_CYCLES plus two cycles to complete before its result is read. Control writes made during busy are issued on purpose, only to exercise the ignore rule.

// File: rtl/otp_ctl_pkg.sv
package otp_ctl_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CFG    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_WDATA  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_GLOCK  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_DBG    = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_DIST   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_ERR    = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_PERM   = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_PLOCK  = 12'h064;
    localparam logic [ADDR_W-1:0] OFS_WLOCK  = 12'h07C;
    localparam logic [ADDR_W-1:0] OFS_RLOCK  = 12'h094;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 12'h200;

    localparam int CTRL_PROG_BIT  = 8;
    localparam int CTRL_LOCK_BIT  = 9;
    localparam int STAT_BUSY_BIT  = 3;
    localparam int STAT_FAIL_BIT  = 4;
    localparam int STAT_PWR_BIT   = 5;
    localparam int GLOCK_PROG_BIT = 4;
    localparam int DBG_BIT        = 10;
    localparam int LOW_REGION     = 32;

    typedef enum logic [1:0] {CMD_RELOAD, CMD_PROGRAM, CMD_PERMLOCK} cmd_e;
    typedef enum logic [1:0] {FSM_IDLE, FSM_WAIT, FSM_APPLY} fsm_e;
endpackage

// File: rtl/otp_pwr_seq.sv
module otp_pwr_seq #(
    parameter int PWR_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rdy_o
);
    localparam int CW = (PWR_DELAY > 1) ? $clog2(PWR_DELAY) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rdy_o <= 1'b0;
        end else if (req_i == rdy_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PWR_DELAY - 1)) begin
            rdy_o <= req_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == rdy_o) |=> $stable(rdy_o)); // R2
    AST_PWR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdy_o) |-> (rdy_o == $past(req_i))); // R2
endmodule

// File: rtl/otp_sticky_map.sv
module otp_sticky_map #(
    parameter int NUM_WORDS = 96,
    parameter int BANK_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [BANK_W-1:0]    set_bank,
    input  logic [31:0]          set_bits,
    output logic [NUM_WORDS-1:0] map_o
);
    localparam int NBANK = NUM_WORDS / 32;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_o <= '0;
        end else if (set_en) begin
            for (int b = 0; b < NBANK; b++) begin
                if (set_bank == BANK_W'(b))
                    map_o[b*32 +: 32] <= map_o[b*32 +: 32] | set_bits;
            end
        end
    end

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((map_o & $past(map_o)) == $past(map_o))); // R11
endmodule

// File: rtl/otp_fuse_ctl.sv
module otp_fuse_ctl
    import otp_ctl_pkg::*;
#(
    parameter int NUM_WORDS   = 96,
    parameter int BUSY_CYCLES = 8,
    parameter int PWR_DELAY   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dbg_en_i
);
    localparam int NBANK       = NUM_WORDS / 32;
    localparam int BANK_W      = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int WORD_W      = $clog2(NUM_WORDS);
    localparam int CNT_W       = $clog2(BUSY_CYCLES);
    localparam int LOCK_GROUPS = LOW_REGION / 8 + (NUM_WORDS - LOW_REGION) / 16;
    localparam logic [ADDR_W-1:0] STICKY_BASE [3] = '{OFS_PLOCK, OFS_WLOCK, OFS_RLOCK};

    // ---------------- register decode ----------------
    logic wr_cfg, wr_ctrl, wr_wdata, wr_glock, wr_shadow;
    logic [WORD_W+1:0] off_sh;
    logic [WORD_W-1:0] sh_idx;

    assign wr_cfg   = bus_we && (bus_addr == OFS_CFG);
    assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    assign wr_wdata = bus_we && (bus_addr == OFS_WDATA);
    assign wr_glock = bus_we && (bus_addr == OFS_GLOCK);
    assign off_sh   = (WORD_W+2)'(bus_addr - OFS_SHADOW);
    assign sh_idx   = off_sh[WORD_W+1:2];
    assign wr_shadow = bus_we && (bus_addr >= OFS_SHADOW)
                     && (bus_addr < OFS_SHADOW + ADDR_W'(4 * NUM_WORDS))
                     && (off_sh[1:0] == 2'b00);

    // ---------------- sticky lock maps ----------------
    logic [NUM_WORDS-1:0] sticky_map [3];
    logic [NUM_WORDS-1:0] plock_map, wlock_map, rlock_map;

    for (genvar g = 0; g < 3; g++) begin : g_sticky
        logic [BANK_W+1:0] off;
        logic              hit;
        assign off = (BANK_W+2)'(bus_addr - STICKY_BASE[g]);
        assign hit = bus_we && (bus_addr >= STICKY_BASE[g])
                   && (bus_addr < STICKY_BASE[g] + ADDR_W'(4 * NBANK))
                   && (off[1:0] == 2'b00);
        otp_sticky_map #(.NUM_WORDS(NUM_WORDS), .BANK_W(BANK_W)) u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (hit),
            .set_bank (off[BANK_W+1:2]),
            .set_bits (bus_wdata),
            .map_o    (sticky_map[g])
        );
    end
    assign plock_map = sticky_map[0];
    assign wlock_map = sticky_map[1];
    assign rlock_map = sticky_map[2];

    // ---------------- power handshake ----------------
    logic pwr_req_q, pwr_rdy;
    otp_pwr_seq #(.PWR_DELAY(PWR_DELAY)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (pwr_req_q),
        .rdy_o (pwr_rdy)
    );

    // ---------------- plain registers ----------------
    logic [31:0] wdata_q, glock_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_req_q <= 1'b0;
            wdata_q   <= '0;
            glock_q   <= '0;
        end else begin
            if (wr_cfg)   pwr_req_q <= bus_wdata[0];
            if (wr_wdata) wdata_q   <= bus_wdata;
            if (wr_glock) glock_q   <= glock_q | bus_wdata;
        end
    end

    // ---------------- command state machine ----------------
    fsm_e              state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    cmd_e              cmd_q;
    logic [WORD_W-1:0] tgt_q;
    logic              accept, busy, do_apply;

    assign accept = wr_ctrl && (state_q == FSM_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FSM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE:  if (accept) state_d = FSM_WAIT;
            FSM_WAIT:  if (cnt_q == '0) state_d = FSM_APPLY;
            FSM_APPLY: state_d = FSM_IDLE;
            default:   state_d = FSM_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != FSM_IDLE);
        do_apply = (state_q == FSM_APPLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmd_q <= CMD_RELOAD;
            tgt_q <= '0;
        end else if (accept) begin
            cnt_q <= CNT_W'(BUSY_CYCLES - 2);
            tgt_q <= bus_wdata[WORD_W-1:0];
            if (bus_wdata[CTRL_PROG_BIT] && bus_wdata[CTRL_LOCK_BIT]) cmd_q <= CMD_PERMLOCK;
            else if (bus_wdata[CTRL_PROG_BIT])                        cmd_q <= CMD_PROGRAM;
            else                                                      cmd_q <= CMD_RELOAD;
        end else if (state_q == FSM_WAIT && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // ---------------- command evaluation ----------------
    logic                 word_ok, grp_ok, fail_now, prog_block;
    logic [WORD_W-1:0]    tgt_safe;
    logic [NUM_WORDS-1:0] perm_q, err_q, dist_q, perm_pick;
    logic                 fail_q;
    logic [31:0]          fuse_q   [NUM_WORDS];
    logic [31:0]          shadow_q [NUM_WORDS];

    assign word_ok  = {1'b0, tgt_q} < (WORD_W+1)'(NUM_WORDS);
    assign grp_ok   = {1'b0, tgt_q} < (WORD_W+1)'(LOCK_GROUPS);
    assign tgt_safe = word_ok ? tgt_q : '0;
    assign prog_block = plock_map[tgt_safe] || glock_q[GLOCK_PROG_BIT];

    always_comb begin
        unique case (cmd_q)
            CMD_RELOAD:   fail_now = !pwr_rdy || !word_ok;
            CMD_PROGRAM:  fail_now = !pwr_rdy || !word_ok || perm_q[tgt_safe];
            CMD_PERMLOCK: fail_now = !pwr_rdy || !grp_ok;
            default:      fail_now = 1'b1;
        endcase
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_perm
        localparam int GRP  = (w < LOW_REGION) ? w / 8 : LOW_REGION / 8 + (w - LOW_REGION) / 16;
        localparam int BITP = (w < LOW_REGION) ? (2 * w) % 16 : w % 16;
        if (w < LOW_REGION) begin : g_pair
            assign perm_pick[w] = (tgt_q == WORD_W'(GRP)) && (wdata_q[BITP+1] || wdata_q[BITP]);
        end else begin : g_single
            assign perm_pick[w] = (tgt_q == WORD_W'(GRP)) && wdata_q[BITP];
        end

        AST_FUSE_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((fuse_q[w] & $past(fuse_q[w])) == $past(fuse_q[w]))); // R5
        AST_PERM_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            perm_q[w] |=> $stable(fuse_q[w])); // R10
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            perm_q <= '0;
            err_q  <= '0;
            dist_q <= '0;
            for (int i = 0; i < NUM_WORDS; i++) fuse_q[i] <= '0;
        end else begin
            if (accept) fail_q <= 1'b0;
            if (do_apply) begin
                fail_q <= fail_now;
                if (cmd_q == CMD_PERMLOCK && !fail_now)
                    perm_q <= perm_q | perm_pick;
                if (cmd_q != CMD_PERMLOCK && word_ok) begin
                    if (fail_now) err_q[tgt_safe] <= 1'b1;
                    else if (cmd_q == CMD_RELOAD || !prog_block) err_q[tgt_safe] <= 1'b0;
                end
                if (cmd_q == CMD_PROGRAM && !fail_now && !prog_block)
                    fuse_q[tgt_safe] <= fuse_q[tgt_safe] | wdata_q;
                if (cmd_q == CMD_RELOAD && !fail_now)
                    dist_q[tgt_safe] <= rlock_map[tgt_safe];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) shadow_q[i] <= '0;
        end else begin
            if (wr_shadow && !wlock_map[sh_idx]) shadow_q[sh_idx] <= bus_wdata;
            if (do_apply && cmd_q == CMD_RELOAD && !fail_now)
                shadow_q[tgt_safe] <= rlock_map[tgt_safe] ? '0 : fuse_q[tgt_safe];
        end
    end

    AST_CTRL_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctrl) |=> ($stable(cmd_q) && $stable(tgt_q))); // R3
    AST_FAIL_AT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> $past(state_q == FSM_APPLY)); // R6

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CFG)   bus_rdata[0] = pwr_req_q;
        if (bus_addr == OFS_WDATA) bus_rdata    = wdata_q;
        if (bus_addr == OFS_GLOCK) bus_rdata    = glock_q;
        if (bus_addr == OFS_DBG)   bus_rdata[DBG_BIT] = dbg_en_i;
        if (bus_addr == OFS_STAT) begin
            bus_rdata[STAT_BUSY_BIT] = busy;
            bus_rdata[STAT_FAIL_BIT] = fail_q;
            bus_rdata[STAT_PWR_BIT]  = pwr_rdy;
        end
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == OFS_DIST + ADDR_W'(4 * b)) bus_rdata = dist_q[b*32 +: 32];
            if (bus_addr == OFS_ERR  + ADDR_W'(4 * b)) bus_rdata = err_q[b*32 +: 32];
            if (bus_addr == OFS_PERM + ADDR_W'(4 * b)) bus_rdata = perm_q[b*32 +: 32];
            for (int g = 0; g < 3; g++) begin
                if (bus_addr == STICKY_BASE[g] + ADDR_W'(4 * b))
                    bus_rdata = sticky_map[g][b*32 +: 32];
            end
        end
        if (bus_addr >= OFS_SHADOW && bus_addr < OFS_SHADOW + ADDR_W'(4 * NUM_WORDS)
            && off_sh[1:0] == 2'b00)
            bus_rdata = shadow_q[sh_idx];
    end
endmodule

// File: tb/otp_fuse_ctl_tb.sv
module otp_fuse_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 8;
    localparam int PWR  = 4;

    localparam logic [11:0] A_CFG = 12'h000, A_CTRL = 12'h004, A_WDATA = 12'h008,
                            A_STAT = 12'h00C, A_GLOCK = 12'h010, A_DBG = 12'h014,
                            A_DIST = 12'h01C, A_ERR = 12'h034, A_PERM = 12'h04C,
                            A_PLOCK = 12'h064, A_WLOCK = 12'h07C, A_RLOCK = 12'h094,
                            A_SH = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_en_i = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    otp_fuse_ctl #(.NUM_WORDS(96), .BUSY_CYCLES(BUSY), .PWR_DELAY(PWR)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_en_i  (dbg_en_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] sh(input int w);
        return A_SH + 12'(4 * w);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic do_cmd(input logic [31:0] ctrl);
        bus_wr(A_CTRL, ctrl);
        repeat (BUSY + 2) @(negedge clk);
    endtask

    task automatic fail_bit(input string tag, input logic exp);
        logic [31:0] d;
        @(negedge clk);
        rd(A_STAT, d);
        check(tag, {31'b0, d[4]}, {31'b0, exp});
    endtask

    task automatic t_reset();
        rd_check("R1 status", A_STAT, 32'h0);
        rd_check("R1 shadow5", sh(5), 32'h0);
        rd_check("R1 shadow95", sh(95), 32'h0);
        rd_check("R1 rlock bank1", A_RLOCK + 12'h4, 32'h0);
        rd_check("R1 perm bank2", A_PERM + 12'h8, 32'h0);
        rd_check("R1 glock", A_GLOCK, 32'h0);
    endtask

    task automatic t_no_power();
        bus_wr(A_WDATA, 32'hF);
        do_cmd(32'h103);
        fail_bit("R6 fail without power", 1'b1);
        rd_check("R6 error bit word3", A_ERR, 32'h8);
    endtask

    task automatic t_power();
        logic [31:0] d;
        bus_wr(A_CFG, 32'h1);
        rd(A_STAT, d);
        check("R2 not ready at once", {31'b0, d[5]}, 32'h0);
        repeat (PWR - 1) @(negedge clk);
        rd(A_STAT, d);
        check("R2 not ready before delay", {31'b0, d[5]}, 32'h0);
        @(negedge clk);
        rd(A_STAT, d);
        check("R2 ready after delay", {31'b0, d[5]}, 32'h1);
        do_cmd(32'h003);
        fail_bit("R6 fail cleared by next command", 1'b0);
        rd_check("R6 error cleared on success", A_ERR, 32'h0);
        rd_check("R6 fuse3 untouched", sh(3), 32'h0);
    endtask

    task automatic t_prog_reload();
        bus_wr(A_WDATA, 32'h0000_00F0);
        do_cmd(32'h10A);
        rd_check("R5 shadow unchanged by program", sh(10), 32'h0);
        bus_wr(A_WDATA, 32'h0F00_0000);
        do_cmd(32'h10A);
        do_cmd(32'h00A);
        rd_check("R5 program ORs bits", sh(10), 32'h0F00_00F0);
        bus_wr(sh(10), 32'h1234);
        rd_check("R4 shadow writable", sh(10), 32'h1234);
        do_cmd(32'h00A);
        rd_check("R4 reload restores fuse", sh(10), 32'h0F00_00F0);
        bus_wr(A_WDATA, 32'hDEAD_0000);
        do_cmd(32'h146);
        do_cmd(32'h046);
        rd_check("R4 reload upper bank word70", sh(70), 32'hDEAD_0000);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        int n = 0;
        bus_wr(A_CTRL, 32'h014);
        rd(A_STAT, d);
        while (d[3] && n < 100) begin
            n++;
            @(negedge clk);
            rd(A_STAT, d);
        end
        check("R3 busy length", 32'(n), 32'(BUSY));
        bus_wr(A_WDATA, 32'h0000_00FF);
        bus_wr(A_CTRL, 32'h014);
        bus_wr(A_CTRL, 32'h114);
        repeat (BUSY + 2) @(negedge clk);
        do_cmd(32'h014);
        rd_check("R3 control write while busy ignored", sh(20), 32'h0);
    endtask

    task automatic t_rlock();
        bus_wr(A_WDATA, 32'h0000_00AA);
        do_cmd(32'h128);
        bus_wr(A_RLOCK + 12'h4, 32'h100);
        do_cmd(32'h028);
        rd_check("R7 read-locked reload gives zero", sh(40), 32'h0);
        rd_check("R7 disturbed bit word40", A_DIST + 12'h4, 32'h100);
    endtask

    task automatic t_wlock();
        bus_wr(sh(50), 32'h55);
        bus_wr(A_WLOCK + 12'h4, 32'h0004_0000);
        bus_wr(sh(50), 32'h66);
        rd_check("R8 write-locked shadow kept", sh(50), 32'h55);
    endtask

    task automatic t_sticky();
        bus_wr(A_RLOCK + 12'h4, 32'h0);
        rd_check("R11 zeros do not clear", A_RLOCK + 12'h4, 32'h100);
        bus_wr(A_RLOCK + 12'h4, 32'h1);
        rd_check("R11 ones accumulate", A_RLOCK + 12'h4, 32'h101);
    endtask

    task automatic t_perm();
        bus_wr(A_WDATA, 32'h0000_0C00);
        do_cmd(32'h300);
        fail_bit("R10 low lock ok", 1'b0);
        rd_check("R10 word5 locked", A_PERM, 32'h20);
        bus_wr(A_WDATA, 32'h1);
        do_cmd(32'h105);
        fail_bit("R10 program of locked word fails", 1'b1);
        do_cmd(32'h005);
        rd_check("R10 locked fuse unchanged", sh(5), 32'h0);
        bus_wr(A_WDATA, 32'h0000_2000);
        do_cmd(32'h306);
        rd_check("R10 word77 locked", A_PERM + 12'h8, 32'h2000);
    endtask

    task automatic t_range();
        do_cmd(32'h064);
        fail_bit("R12 word out of range", 1'b1);
        do_cmd(32'h309);
        fail_bit("R12 lock group out of range", 1'b1);
        rd_check("R12 perm bank0 unchanged", A_PERM, 32'h20);
    endtask

    task automatic t_debug();
        dbg_en_i = 1'b1;
        rd_check("R13 debug set", A_DBG, 32'h400);
        dbg_en_i = 1'b0;
        rd_check("R13 debug clear", A_DBG, 32'h0);
    endtask

    task automatic t_prog_locks();
        bus_wr(A_PLOCK + 12'h4, 32'h1000_0000);
        bus_wr(A_WDATA, 32'h1);
        do_cmd(32'h13C);
        fail_bit("R9 sticky-locked program no fail", 1'b0);
        do_cmd(32'h03C);
        rd_check("R9 sticky-locked program ignored", sh(60), 32'h0);
        bus_wr(A_GLOCK, 32'h10);
        bus_wr(A_WDATA, 32'h2);
        do_cmd(32'h13D);
        fail_bit("R9 global-locked program no fail", 1'b0);
        do_cmd(32'h03D);
        rd_check("R9 global-locked program ignored", sh(61), 32'h0);
        bus_wr(A_GLOCK, 32'h0);
        rd_check("R11 global lock kept", A_GLOCK, 32'h10);
    endtask

    task automatic t_power_off();
        logic [31:0] d;
        bus_wr(A_CFG, 32'h0);
        repeat (PWR + 2) @(negedge clk);
        rd(A_STAT, d);
        check("R2 ready drops", {31'b0, d[5]}, 32'h0);
        bus_wr(sh(10), 32'h777);
        do_cmd(32'h00A);
        fail_bit("R6 reload without power fails", 1'b1);
        rd_check("R6 shadow kept without power", sh(10), 32'h777);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_power();
        t_power();
        t_prog_reload();
        t_busy();
        t_rlock();
        t_wlock();
        t_sticky();
        t_perm();
        t_range();
        t_debug();
        t_prog_locks();
        t_power_off();
        finish_run();
    end
endmodule